// File: doc/BRIEF.md
# Configurable DMA Channel Transfer Engine

This block sequences the transfers of one DMA channel. Software loads the channel configuration while the channel is off: a transfer mode, a separate addressing mode and element width for the source and for the destination, a stride factor for each side, the two start addresses and an element count. Setting the enable copies those values into the working registers. Each accepted trigger then moves either one element or the whole remaining block, depending on the mode.

Each element is moved as one read request followed by one write request on a simple single-beat interface. A request is held until the memory side acknowledges it. The value read is zero-extended or truncated to the narrower of the two widths before it is written. After each write the engine steps both addresses and counts the element down. Once the count is used up, the engine either turns itself off or, in the repeating modes, reloads its start values and stays on. A one-cycle completion pulse marks the end of every block or count cycle.

Top module: `dma_chan_seq`

## Requirements
- R1: With `cfg_mode` 0 (single) or 2 (repeated single), each accepted trigger moves exactly one element.
- R2: With `cfg_mode` 1 (block) or 3 (repeated block), one accepted trigger moves all remaining elements back to back with no further trigger.
- R3: In modes 0 and 1, `ch_en` drops to 0 once the last element of the programmed count has been written.
- R4: In modes 2 and 3, after the last element the source address, destination address and count reload to the programmed values, and `ch_en` stays 1.
- R5: Addressing code per side: 0 decrements the address by the element size in bytes, 1 keeps it fixed, 2 increments it by the element size, and 3 adds stride times the element size. Any addressing code combines with any mode.
- R6: Width code per side: 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes, and codes above 4 act as 16 bytes. `rd_size`/`wr_size` carry the code (saturated at 4). `wr_data` is the read value with every bit above the narrower of the two widths forced to 0.
- R7: A trigger is ignored while `ch_en` is 0 and while a block is running in modes 1 and 3. In modes 0 and 2, a trigger that arrives while an element is in flight is held as one pending request and is served afterwards.
- R8: With a programmed count of 0, no trigger starts a read.
- R9: `done` is high for exactly one cycle, the cycle after the write acknowledge of the last element of a block or count cycle, and at no other time.
- R10: `cfg_wr` updates the configuration only while `ch_en` is 0. `en_set` while `ch_en` is 0 raises it and loads the working addresses and count from the programmed values. `en_set` has no effect while `ch_en` is 1.
- R11: A read or write request stays high with a stable address until it is acknowledged. An acknowledged read is followed at once by the write request, and the two requests are never high together.
- R12: After reset, `ch_en`, `rd_req`, `wr_req` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load configuration inputs (only while disabled) |
| cfg_mode | input | 2 | Transfer mode |
| cfg_src_am | input | 2 | Source addressing code |
| cfg_dst_am | input | 2 | Destination addressing code |
| cfg_src_w | input | 3 | Source width code |
| cfg_dst_w | input | 3 | Destination width code |
| cfg_src_stride | input | SW | Source stride factor |
| cfg_dst_stride | input | SW | Destination stride factor |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_count | input | CW | Elements per block / count cycle |
| en_set | input | 1 | Enable the channel and load working values |
| en_clr | input | 1 | Disable the channel |
| trig | input | 1 | Transfer trigger |
| ch_en | output | 1 | Channel enable state |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_size | output | 3 | Read width code |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 128 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_size | output | 3 | Write width code |
| wr_data | output | 128 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | End-of-block pulse |

## Verification
The assertions assume that the memory side raises `rd_ack` and `wr_ack` only while the matching request is high. They also assume that `en_clr` is never used to break off a running block, since the handshake and pulse properties are only meaningful for whole blocks. The bench keeps to this. Its acknowledges are gated by the requests, with random stall cycles from a fixed seed. It raises `en_clr` only when the engine is idle, and it changes configuration only between cases. The random cases draw modes, addressing codes, widths 0 to 4, small strides and counts from 1 to 5. Directed cases cover zero count, triggers while disabled, pending and mid-block triggers, and writes to the configuration while the channel is enabled.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_src_am,
  input  logic [1:0]    cfg_dst_am,
  input  logic [2:0]    cfg_src_w,
  input  logic [2:0]    cfg_dst_w,
  input  logic [SW-1:0] cfg_src_stride,
  input  logic [SW-1:0] cfg_dst_stride,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          trig,
  output logic          ch_en,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [2:0]    rd_size,
  input  logic          rd_ack,
  input  logic [127:0]  rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [2:0]    wr_size,
  output logic [127:0]  wr_data,
  input  logic          wr_ack,
  output logic          done
);
  localparam logic [1:0] S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2;

  logic [1:0]    st, mode, sam, dam;
  logic [2:0]    ssz, dsz;
  logic [SW-1:0] sstr, dstr;
  logic [AW-1:0] sh_src, sh_dst, src, dst;
  logic [CW-1:0] sh_cnt, rem;
  logic          pend;
  logic [127:0]  dbuf;

  function automatic logic [2:0] sat(input logic [2:0] c);
    return (c > 3'd4) ? 3'd4 : c;
  endfunction

  function automatic logic [AW-1:0] nbytes(input logic [2:0] c);
    return AW'(1) << sat(c);
  endfunction

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] am,
                                         input logic [2:0] c, input logic [SW-1:0] s);
    case (am)
      2'd0:    return a - nbytes(c);
      2'd1:    return a;
      2'd2:    return a + nbytes(c);
      default: return a + AW'(s) * nbytes(c);
    endcase
  endfunction

  function automatic logic [127:0] keep(input logic [2:0] c);
    logic [127:0] m;
    for (int i = 0; i < 16; i++)
      m[i*8 +: 8] = (i < (1 << sat(c))) ? 8'hFF : 8'h00;
    return m;
  endfunction

  wire [2:0] nsz   = (sat(ssz) < sat(dsz)) ? sat(ssz) : sat(dsz);
  wire       start = ch_en && rem != '0 && (trig || pend);
  wire       last  = rem == CW'(1);

  assign rd_req  = st == S_RD;
  assign wr_req  = st == S_WR;
  assign rd_addr = src;
  assign wr_addr = dst;
  assign rd_size = sat(ssz);
  assign wr_size = sat(dsz);
  assign wr_data = dbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode <= '0; sam <= '0; dam <= '0; ssz <= '0; dsz <= '0;
      sstr <= '0; dstr <= '0; sh_src <= '0; sh_dst <= '0; sh_cnt <= '0;
      src <= '0; dst <= '0; rem <= '0; pend <= 1'b0; dbuf <= '0;
      ch_en <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cfg_wr && !ch_en) begin
        mode <= cfg_mode; sam <= cfg_src_am; dam <= cfg_dst_am;
        ssz <= cfg_src_w; dsz <= cfg_dst_w;
        sstr <= cfg_src_stride; dstr <= cfg_dst_stride;
        sh_src <= cfg_src_addr; sh_dst <= cfg_dst_addr; sh_cnt <= cfg_count;
      end
      if (en_set && !ch_en) begin
        ch_en <= 1'b1; src <= sh_src; dst <= sh_dst; rem <= sh_cnt; pend <= 1'b0;
      end
      if (trig && ch_en && st != S_IDLE && !mode[0]) pend <= 1'b1;
      if (en_clr) begin
        ch_en <= 1'b0; pend <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_RD; pend <= 1'b0;
        end
        S_RD: if (rd_ack) begin
          dbuf <= rd_data & keep(nsz);
          st   <= S_WR;
        end
        S_WR: if (wr_ack) begin
          src <= step(src, sam, ssz, sstr);
          dst <= step(dst, dam, dsz, dstr);
          rem <= rem - CW'(1);
          if (last) begin
            done <= 1'b1;
            st   <= S_IDLE;
            if (mode[1]) begin
              src <= sh_src; dst <= sh_dst; rem <= sh_cnt;
            end else begin
              ch_en <= 1'b0; pend <= 1'b0;
            end
          end else begin
            st <= (mode[0] && ch_en && !en_clr) ? S_RD : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic          done
);
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_req && wr_req)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) wr_req && !wr_ack |=> wr_req && $stable(wr_addr)); // R11
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) rd_req && rd_ack |=> wr_req); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(wr_req && wr_ack)); // R9
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .done(done)
);

// File: tb/dma_chan_seq_tb_top.sv
module dma_chan_seq_tb_top;
  localparam int AW = 32, CW = 16, SW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_wr = 0, en_set = 0, en_clr = 0, trig = 0;
  logic [1:0] cfg_mode = 0, cfg_src_am = 0, cfg_dst_am = 0;
  logic [2:0] cfg_src_w = 0, cfg_dst_w = 0;
  logic [SW-1:0] cfg_src_stride = 0, cfg_dst_stride = 0;
  logic [AW-1:0] cfg_src_addr = 0, cfg_dst_addr = 0;
  logic [CW-1:0] cfg_count = 0;
  logic ch_en, rd_req, rd_ack, wr_req, wr_ack, done, stall;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [2:0] rd_size, wr_size;
  logic [127:0] rd_data, wr_data;

  function automatic logic [127:0] memf(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_C3C3, a * 32'd3, a + 32'h1111};
  endfunction

  assign rd_data = memf(rd_addr);
  assign rd_ack  = rd_req && !stall;
  assign wr_ack  = wr_req && !stall;
  always @(posedge clk) stall <= ($urandom % 4) == 0;

  dma_chan_seq #(.AW(AW), .CW(CW), .SW(SW)) dut_i (.*);

  int checks = 0, fails = 0, n_rd = 0, n_wr = 0, n_done = 0;
  logic [1:0] m_mode, m_sam, m_dam;
  logic [2:0] m_ssz, m_dsz;
  logic [SW-1:0] m_sst, m_dst_s;
  logic [31:0] m_sa, m_da, m_src, m_dst;
  int m_cnt, m_rem;
  logic last_fin = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [2:0] c);
    return 1 << ((c > 4) ? 4 : c);
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] am,
                                      input logic [2:0] c, input logic [SW-1:0] s);
    case (am)
      2'd0: return a - nb(c);
      2'd1: return a;
      2'd2: return a + nb(c);
      default: return a + s * nb(c);
    endcase
  endfunction

  function automatic logic [127:0] expd(input logic [31:0] a);
    int k = (nb(m_ssz) < nb(m_dsz)) ? nb(m_ssz) : nb(m_dsz);
    logic [127:0] m = '0;
    for (int i = 0; i < k; i++) m[i*8 +: 8] = 8'hFF;
    return memf(a) & m;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (done || last_fin) chk(done == last_fin, "R9 done timing", done, last_fin);
    if (done) n_done++;
    last_fin = 0;
    if (rd_req && rd_ack) begin
      n_rd++;
      chk(rd_addr == m_src, "R5 read address", rd_addr, m_src);
      chk(rd_size == m_ssz, "R6 read size", rd_size, m_ssz);
    end
    if (wr_req && wr_ack) begin
      n_wr++;
      chk(wr_addr == m_dst, "R5 write address", wr_addr, m_dst);
      chk(wr_size == m_dsz, "R6 write size", wr_size, m_dsz);
      chk(wr_data == expd(m_src), "R6 write data", wr_data, expd(m_src));
      m_src = nxt(m_src, m_sam, m_ssz, m_sst);
      m_dst = nxt(m_dst, m_dam, m_dsz, m_dst_s);
      m_rem--;
      if (m_rem == 0) begin
        last_fin = 1;
        if (m_mode[1]) begin m_src = m_sa; m_dst = m_da; m_rem = m_cnt; end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig;
    @(negedge clk) trig = 1; @(negedge clk) trig = 0;
  endtask

  task automatic setup(input logic [1:0] md, sa_m, da_m, input logic [2:0] sw, dw,
                       input logic [SW-1:0] ss, ds, input logic [31:0] sa, da, input int cnt);
    @(negedge clk) en_clr = 1; @(negedge clk) en_clr = 0;
    cfg_mode = md; cfg_src_am = sa_m; cfg_dst_am = da_m; cfg_src_w = sw; cfg_dst_w = dw;
    cfg_src_stride = ss; cfg_dst_stride = ds; cfg_src_addr = sa; cfg_dst_addr = da;
    cfg_count = CW'(cnt); cfg_wr = 1;
    @(negedge clk) cfg_wr = 0; en_set = 1;
    m_mode = md; m_sam = sa_m; m_dam = da_m; m_ssz = sw; m_dsz = dw; m_sst = ss; m_dst_s = ds;
    m_sa = sa; m_da = da; m_src = sa; m_dst = da; m_cnt = cnt; m_rem = cnt;
    @(negedge clk) en_set = 0;
  endtask

  task automatic wait_wr(input int target, input string req);
    int t = 0;
    while (n_wr < target && t < 400) begin @(negedge clk); t++; end
    chk(n_wr >= target, req, n_wr, target);
  endtask

  task automatic run(input logic [1:0] md, input int cnt, input int rounds);
    int w0 = n_wr, d0 = n_done;
    for (int r = 0; r < rounds; r++) begin
      if (md[0]) begin
        pulse_trig();
        wait_wr(w0 + (r + 1) * cnt, "R2 block completes on one trigger");
      end else
        for (int e = 0; e < cnt; e++) begin
          pulse_trig();
          wait_wr(w0 + r * cnt + e + 1, "R1 one element per trigger");
          cyc(2);
          chk(n_wr == w0 + r * cnt + e + 1, "R1 exactly one element", n_wr, w0 + r * cnt + e + 1);
        end
      cyc(3);
    end
    chk(n_wr == w0 + rounds * cnt, "R2 element total", n_wr, w0 + rounds * cnt);
    chk(n_done == d0 + rounds, "R9 done count", n_done, d0 + rounds);
    if (md[1]) chk(ch_en == 1, "R4 enable kept in repeat mode", ch_en, 1);
    else       chk(ch_en == 0, "R3 enable cleared at end", ch_en, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int w0, r0;
    void'($urandom(32'd2024));
    cyc(3);
    chk(ch_en == 0 && rd_req == 0 && wr_req == 0 && done == 0, "R12 reset state",
        {ch_en, rd_req, wr_req, done}, 0);
    @(negedge clk) rst_n = 1;
    cyc(2);
    chk(ch_en == 0 && rd_req == 0 && wr_req == 0 && done == 0, "R12 after reset release",
        {ch_en, rd_req, wr_req, done}, 0);

    // R7: trigger while disabled
    cfg_count = 4; cfg_mode = 1; cfg_wr = 1; @(negedge clk) cfg_wr = 0;
    pulse_trig(); cyc(20);
    chk(n_rd == 0, "R7 trigger ignored while disabled", n_rd, 0);

    // R8: zero count
    setup(2'd3, 2'd2, 2'd2, 3'd2, 3'd2, 1, 1, 32'h100, 32'h200, 0);
    r0 = n_rd; pulse_trig(); cyc(20);
    chk(n_rd == r0, "R8 zero count starts nothing", n_rd, r0);
    chk(ch_en == 1, "R10 en_set raises enable", ch_en, 1);

    // R5/R6 directed: decrement source, stride destination, wide to narrow
    setup(2'd1, 2'd0, 2'd3, 3'd4, 3'd0, 0, 3, 32'h8000, 32'h4000, 4);
    run(2'd1, 4, 1);
    // narrow to wide, fixed source, increment destination, repeat single
    setup(2'd2, 2'd1, 2'd2, 3'd1, 3'd3, 0, 0, 32'h9000, 32'h1000, 3);
    run(2'd2, 3, 2);

    // R7: pending trigger in single mode
    setup(2'd0, 2'd2, 2'd2, 3'd2, 3'd2, 0, 0, 32'h500, 32'h600, 4);
    w0 = n_wr;
    @(negedge clk) trig = 1; @(negedge clk) trig = 1; @(negedge clk) trig = 0;
    wait_wr(w0 + 2, "R7 pending trigger served");
    cyc(10);
    chk(n_wr == w0 + 2, "R7 one pending request only", n_wr, w0 + 2);

    // R7: trigger during a running block is ignored
    setup(2'd3, 2'd2, 2'd2, 3'd0, 3'd0, 0, 0, 32'h700, 32'h800, 4);
    w0 = n_wr;
    pulse_trig(); pulse_trig();
    wait_wr(w0 + 4, "R2 repeated block");
    cyc(30);
    chk(n_wr == w0 + 4, "R7 mid-block trigger ignored", n_wr, w0 + 4);
    chk(ch_en == 1, "R4 enable kept", ch_en, 1);

    // R10: config write and en_set while enabled have no effect
    setup(2'd2, 2'd2, 2'd2, 3'd2, 3'd2, 0, 0, 32'h1_0000, 32'h2_0000, 2);
    @(negedge clk) cfg_src_addr = 32'hDEAD_0000; cfg_dst_addr = 32'hBEEF_0000;
    cfg_count = 7; cfg_wr = 1; en_set = 1;
    @(negedge clk) cfg_wr = 0; en_set = 0;
    run(2'd2, 2, 2);

    // random cases
    for (int i = 0; i < 40; i++) begin
      logic [1:0] md = 2'($urandom % 4);
      int cnt = 1 + $urandom % 5;
      setup(md, 2'($urandom % 4), 2'($urandom % 4), 3'($urandom % 5), 3'($urandom % 5),
            SW'(1 + $urandom % 5), SW'(1 + $urandom % 5),
            32'h1000_0000 + ($urandom % 65536) * 16, 32'h2000_0000 + ($urandom % 65536) * 16, cnt);
      run(md, cnt, md[1] ? 1 + $urandom % 2 : 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule